// File: doc/BRIEF.md
# Partitioned SIMD Packed Adder

This block is a 64-bit integer adder that can split itself into narrower lanes. It can work as one 64-bit lane, two 32-bit lanes, four 16-bit lanes or eight 8-bit lanes. Every lane performs the same operation in the same cycle, either an add or a subtract. The datapath is built from eight byte-wide adder slices. A slice either takes the carry from the slice below it or starts a fresh lane, depending on the selected width. No extra adders are spent on the narrower formats.

Every lane wraps modulo its own width and reports its own carry-out. In subtract mode, a carry-out of 1 means the lane did not borrow. The result and the carries pass through one output register by default, so results appear one clock after the operands are presented.

Top module: `simd_split_adder`

## Requirements
- R1: With `mode` = 2'b00, `sum` is the 64-bit add or subtract of the operands, and `lane_cout[0]` is the carry out of bit 63.
- R2: With `mode` = 2'b01, bits 31:0 and bits 63:32 are two independent 32-bit lanes. `lane_cout[0]` belongs to the low lane and `lane_cout[1]` to the high lane.
- R3: With `mode` = 2'b10, there are four independent 16-bit lanes. Lane k occupies bits 16k+15:16k and reports on `lane_cout[k]`.
- R4: With `mode` = 2'b11, there are eight independent 8-bit lanes. Lane k occupies bits 8k+7:8k and reports on `lane_cout[k]`.
- R5: A carry leaving the top bit of a lane never enters the next lane. For example, all-ones plus one in every lane gives zero in every lane, with every used carry bit set.
- R6: With `sub` = 1, each lane computes a + ~b + 1 within its own width. The lane's carry-out is 1 exactly when a >= b, both read as unsigned numbers of that width.
- R7: Bits of `lane_cout` at or above the number of active lanes read 0.
- R8: Outputs are registered with a latency of one clock. While `rst_n` is low, `sum` and `lane_cout` are 0.
- R9: Lane arithmetic wraps modulo 2^width, with no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Lane format: 00 = 1x64, 01 = 2x32, 10 = 4x16, 11 = 8x8 |
| sub | input | 1 | 1 = subtract op_b from op_a, 0 = add |
| op_a | input | 64 | First packed operand |
| op_b | input | 64 | Second packed operand |
| sum | output | 64 | Packed result |
| lane_cout | output | 8 | Carry-out per lane; unused bits are 0 |

## Verification
The hardest case to reach is a carry that would cross a lane boundary when it must not. That only happens when the low lane overflows exactly while the neighbouring lane would visibly change if it received the carry. The stimulus builds this deliberately: all-ones plus one per lane, and equal operands in subtract mode, in every format. Back-to-back format switches follow, so that a stale boundary decision would show in the next result. Random operands are then checked against a lane-by-lane model that is computed with wide arithmetic, not byte slices.

// File: rtl/simd_split_adder.sv
module simd_split_adder #(
  parameter int REG_OUT = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  mode,
  input  logic        sub,
  input  logic [63:0] op_a,
  input  logic [63:0] op_b,
  output logic [63:0] sum,
  output logic [7:0]  lane_cout
);
  localparam int NBYTE = 8;

  logic [63:0]      b_eff;
  logic [NBYTE-1:0] start;
  logic [NBYTE-1:0] cin;
  logic [NBYTE-1:0] co;
  logic [63:0]      s_c;
  logic [7:0]       c_c;
  logic [2:0]       shift;

  assign b_eff = op_b ^ {64{sub}};
  assign shift = 3'd3 - {1'b0, mode};

  for (genvar i = 0; i < NBYTE; i++) begin : g_slice
    assign start[i] = (i == 0) || (mode == 2'b11) ||
                      (mode == 2'b10 && (i % 2) == 0) ||
                      (mode == 2'b01 && (i % 4) == 0);
    if (i == 0) begin : g_first
      assign cin[i] = sub;
    end else begin : g_rest
      assign cin[i] = start[i] ? sub : co[i-1];
    end
    assign {co[i], s_c[8*i+7:8*i]} = {1'b0, op_a[8*i+7:8*i]}
                                   + {1'b0, b_eff[8*i+7:8*i]}
                                   + {8'd0, cin[i]};
  end

  always_comb begin
    c_c = '0;
    for (int i = 0; i < NBYTE; i++) begin
      if (i == NBYTE-1 || start[(i+1) % NBYTE])
        c_c[3'(i) >> shift] = co[i];
    end
  end

  if (REG_OUT != 0) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum       <= '0;
        lane_cout <= '0;
      end else begin
        sum       <= s_c;
        lane_cout <= c_c;
      end
    end
  end else begin : g_comb
    assign sum       = s_c;
    assign lane_cout = c_c;
  end
endmodule

module simd_split_adder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  mode,
  input logic        sub,
  input logic [63:0] op_a,
  input logic [63:0] op_b,
  input logic [63:0] sum,
  input logic [7:0]  lane_cout
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R8: assert (sum == '0 && lane_cout == '0);
    end
  end

  assert_single_lane_cout_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |=> (lane_cout[7:1] == '0));
  assert_two_lane_cout_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |=> (lane_cout[7:2] == '0));
  assert_four_lane_cout_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |=> (lane_cout[7:4] == '0));

  assert_sub_self_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sub && op_a == op_b) |=> (sum == '0 &&
      lane_cout == ($past(mode) == 2'b11 ? 8'hFF : $past(mode) == 2'b10 ? 8'h0F :
                    $past(mode) == 2'b01 ? 8'h03 : 8'h01)));

  assert_byte_add_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sub && mode == 2'b11 && op_b == '0) |=> (sum == $past(op_a) && lane_cout == '0));

  assert_no_cross_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sub && mode == 2'b11 && op_a == '1 && op_b == 64'h0101010101010101)
    |=> (sum == '0 && lane_cout == 8'hFF));

  assert_wide_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sub && mode == 2'b00 && op_a == '1 && op_b == 64'd1)
    |=> (sum == '0 && lane_cout == 8'h01));
endmodule

bind simd_split_adder simd_split_adder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .sub(sub),
  .op_a(op_a), .op_b(op_b), .sum(sum), .lane_cout(lane_cout)
);

// File: tb/simd_split_adder_tb.sv
module simd_split_adder_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  mode = 0;
  logic        sub = 0;
  logic [63:0] op_a = 0;
  logic [63:0] op_b = 0;
  logic [63:0] sum;
  logic [7:0]  lane_cout;

  typedef struct {
    logic [63:0] e_sum;
    logic [7:0]  e_cout;
    string       tag;
  } item_t;

  item_t q[$];
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  simd_split_adder u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .sub(sub),
    .op_a(op_a), .op_b(op_b), .sum(sum), .lane_cout(lane_cout)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic void model(input logic [63:0] a, input logic [63:0] b,
                                input logic [1:0] m, input logic s,
                                output logic [63:0] r, output logic [7:0] c);
    int w = 64 >> m;
    int n = 1 << m;
    logic [127:0] mask = (128'd1 << w) - 128'd1;
    logic [127:0] av, bv, t;
    r = '0;
    c = '0;
    for (int k = 0; k < n; k++) begin
      av = ({64'd0, a} >> (k*w)) & mask;
      bv = ({64'd0, b} >> (k*w)) & mask;
      if (s) bv = ~bv & mask;
      t = av + bv + {127'd0, s};
      r = r | 64'((t & mask) << (k*w));
      c[k] = t[w];
    end
  endfunction

  task automatic drive(input logic [1:0] m, input logic s,
                       input logic [63:0] a, input logic [63:0] b, input string tag);
    item_t it;
    @(negedge clk);
    mode = m; sub = s; op_a = a; op_b = b;
    model(a, b, m, s, it.e_sum, it.e_cout);
    it.tag = tag;
    q.push_back(it);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_run++;
        if (sum !== it.e_sum || lane_cout !== it.e_cout) begin
          n_fail++;
          $display("FAIL %s: sum=%h cout=%h expected sum=%h cout=%h",
                   it.tag, sum, lane_cout, it.e_sum, it.e_cout);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    n_run++;
    if (sum !== '0 || lane_cout !== '0) begin
      n_fail++;
      $display("FAIL R8: reset sum=%h cout=%h expected sum=0 cout=0", sum, lane_cout);
    end
    @(negedge clk);
    rst_n = 1;

    drive(2'b00, 0, 64'h0123456789ABCDEF, 64'h1111111111111111, "R1");
    drive(2'b00, 0, 64'hFFFFFFFFFFFFFFFF, 64'd1, "R1 R9");
    drive(2'b00, 1, 64'd5, 64'd7, "R1 R6");
    drive(2'b01, 0, 64'h00000001FFFFFFFF, 64'h0000000000000001, "R2 R5");
    drive(2'b01, 1, 64'h0000000500000003, 64'h0000000300000005, "R2 R6");
    drive(2'b10, 0, 64'hFFFF0000FFFF1234, 64'h0001000000011111, "R3 R5");
    drive(2'b10, 1, 64'h8000000100020003, 64'h8000000200020001, "R3 R6");
    drive(2'b11, 0, 64'hFFFFFFFFFFFFFFFF, 64'h0101010101010101, "R4 R5");
    drive(2'b11, 0, 64'h807F0102FE01AA55, 64'h80010203020155AA, "R4 R9");
    drive(2'b11, 1, 64'h0001020304050607, 64'h0001020304050607, "R4 R6");
    drive(2'b00, 0, 64'h00000000FFFFFFFF, 64'd1, "R1 R7");
    drive(2'b11, 1, 64'h00FF00FF00FF00FF, 64'h0100010001000100, "R4 R6 R7");
    drive(2'b01, 0, 64'hFFFFFFFFFFFFFFFF, 64'h0000000100000001, "R2 R5 R7");
    drive(2'b10, 0, 64'hFFFFFFFFFFFFFFFF, 64'h0001000100010001, "R3 R5 R7");
    for (int i = 0; i < 400; i++) begin
      drive(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
            {$urandom(), $urandom()}, {$urandom(), $urandom()}, "R9 R7 random");
    end
    @(negedge clk);
    repeat (3) @(posedge clk);
    #2;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule